// File: doc/BRIEF.md
# Block Floating Point Pass Scaler

This block sits between two passes of an in-place, iterative FFT engine. It takes in the complex results of one pass, which have grown by a few bits above the working width, and holds them in an internal buffer. While the block is arriving, it tracks how close any real or imaginary part comes to the top of the wider input word. When the last sample of the pass has arrived, it picks one right-shift amount for the whole block. That amount is just large enough to bring the largest sample back into the working width. The block then streams the buffered samples back out in arrival order, shifted, rounded and saturated to the working width.

Each shift is subtracted from a signed block exponent that runs across all passes of one transform. A flag on the first sample of a pass restarts the exponent at zero for a new transform. A second flag marks the final pass, and for that pass the exponent is presented alongside every output sample. The true magnitude of a result is the output sample multiplied by two to the power of minus the exponent. Both streams use valid/ready handshakes. The block accepts input only while it is filling and offers output only while it is draining.

Top module: `bfp_pass_scaler`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are low. In the first cycle after reset is released, `in_ready` is high, `out_valid` is low and the exponent is zero.
- R2: A pass consists of exactly `N_PTS` accepted input samples (`in_valid` and `in_ready` both high at a clock edge). After the last of them, `in_ready` is low and `out_valid` is high. While draining, input is never accepted, and a sample offered during the drain has no effect on any later block.
- R3: The shift for a block is the smallest s in 0..`G` such that every real and imaginary part of every sample in the block fits in `W`+s signed bits. A block that fits in `W` bits, including the value -2^(`W`-1), is passed with no shift. Growth in the imaginary part alone counts the same as growth in the real part.
- R4: Every sample of a block gets the same shift, and the outputs leave in the order the inputs arrived.
- R5: A shift of k>0 rounds to nearest, with ties away from zero. For example, with k=1: 5→3, -5→-3, 1→1, -1→-1, 4→2.
- R6: A rounded result outside the signed `W`-bit range saturates. For example, with `W`=12, 16383 shifted by 3 gives 2047.
- R7: `in_first`, sampled with the first sample of a pass, starts the exponent from zero. Otherwise the previous exponent is the base. In both cases, at the end of the fill the exponent becomes base minus the block's shift.
- R8: `out_exp_valid` is high exactly while `out_valid` is high for a pass whose first sample carried `in_last` high. During that pass, `out_exp` holds the accumulated exponent.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re` and `out_im` hold their values.
- R10: After `N_PTS` accepted outputs, `out_valid` falls and `in_ready` is high in the next cycle. The next block's shift depends only on that block's own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block is filling and takes the sample |
| in_re | input | W+G | Real part of grown pass result, two's complement |
| in_im | input | W+G | Imaginary part of grown pass result, two's complement |
| in_first | input | 1 | First pass of a transform; sampled with the pass's first sample |
| in_last | input | 1 | Final pass of a transform; sampled with the pass's first sample |
| out_valid | output | 1 | Scaled sample offered |
| out_ready | input | 1 | Downstream takes the sample |
| out_re | output | W | Scaled real part |
| out_im | output | W | Scaled imaginary part |
| out_exp_valid | output | 1 | Exponent valid, final pass only |
| out_exp | output | clog2(NUM_PASS*G+1)+1 | Signed accumulated block exponent |

## Verification
The assertions take for granted that the downstream side keeps `out_ready` as a plain level and that a transform uses no more than `NUM_PASS` passes. Beyond that many passes, the claim that the exponent is never positive would no longer follow from the exponent's width. The bench keeps to these limits by running transforms of at most two passes and by changing `out_ready` only on falling clock edges. It offers junk input during a drain to show that it is refused, and it stalls the output in mid-block to check that the output holds.

// File: rtl/bfp_pkg.sv
// Package: shared types for the block floating point pass scaler.
// Assumes nothing beyond a two-phase fill/drain operation.
package bfp_pkg;

    // Phase of the scaler: collecting a pass, or emitting it scaled.
    typedef enum logic [0:0] {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } bfp_phase_e;

endpackage

// File: rtl/bfp_sign_bits.sv
// Module: bfp_sign_bits
// Counts the redundant sign bits below the MSB of a two's complement word,
// capped at CAP. A result of CAP or more means the value already fits in
// IW-CAP bits, which includes the most negative value of that width.
// Assumes IW > CAP and CW bits can hold CAP.
module bfp_sign_bits #(
    parameter int IW  = 15,
    parameter int CAP = 3,
    parameter int CW  = 2
) (
    input  logic [IW-1:0] value,
    output logic [CW-1:0] headroom
);

    int   cnt;
    logic run;

    // Walk down from the MSB while the bits repeat the sign.
    always_comb begin
        cnt = 0;
        run = 1'b1;
        for (int i = IW - 2; i >= 0; i--) begin
            if (run && (value[i] == value[IW-1])) begin
                cnt = cnt + 1;
            end else begin
                run = 1'b0;
            end
        end
        headroom = (cnt >= CAP) ? CW'(CAP) : CW'(cnt);
    end

endmodule

// File: rtl/bfp_round_sat.sv
// Module: bfp_round_sat
// Arithmetic right shift of a signed IW-bit value by shamt. It rounds to
// nearest with ties away from zero, then saturates to OW signed bits.
// Assumes shamt <= IW-1 and OW < IW.
module bfp_round_sat #(
    parameter int IW = 15,
    parameter int OW = 12,
    parameter int SW = 2
) (
    input  logic [IW-1:0] din,
    input  logic [SW-1:0] shamt,
    output logic [OW-1:0] dout
);

    localparam logic signed [IW:0] ONE  = (IW+1)'(1);
    localparam logic signed [IW:0] MAXV = (IW+1)'((1 << (OW - 1)) - 1);
    localparam logic signed [IW:0] MINV = -((IW+1)'(1 << (OW - 1)));

    logic signed [IW:0] ext;
    logic signed [IW:0] bias;
    logic signed [IW:0] shifted;

    // Add the rounding bias (one less for negatives) and shift.
    always_comb begin
        ext  = {din[IW-1], din};
        bias = '0;
        if (shamt != '0) begin
            bias = ONE <<< (shamt - SW'(1));
            if (din[IW-1]) begin
                bias = bias - ONE;
            end
        end
        shifted = (ext + bias) >>> shamt;
    end

    // Clamp into the output range.
    always_comb begin
        if (shifted > MAXV) begin
            dout = MAXV[OW-1:0];
        end else if (shifted < MINV) begin
            dout = MINV[OW-1:0];
        end else begin
            dout = shifted[OW-1:0];
        end
    end

endmodule

// File: rtl/bfp_sample_buf.sv
// Module: bfp_sample_buf
// Register-array buffer holding one pass of packed complex samples.
// It has one write port and an asynchronous read port. The contents are
// not reset; they are read only after a full pass has been written.
module bfp_sample_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 30
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the sample being drained.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/bfp_pass_scaler.sv
// Module: bfp_pass_scaler (top)
// Buffers one FFT pass of grown complex results and tracks the worst-case
// headroom across the block. At the end of the fill it fixes one right
// shift for the block and updates the running signed exponent. It then
// drains the block, shifted, rounded and saturated to W bits.
// Assumes N_PTS is a power of two and at most NUM_PASS passes per
// transform. in_first and in_last are sampled with each pass's first sample.
module bfp_pass_scaler
    import bfp_pkg::*;
#(
    parameter int N_PTS    = 16,
    parameter int W        = 12,
    parameter int G        = 3,
    parameter int NUM_PASS = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    output logic                                   in_ready,
    input  logic [W+G-1:0]                         in_re,
    input  logic [W+G-1:0]                         in_im,
    input  logic                                   in_first,
    input  logic                                   in_last,
    output logic                                   out_valid,
    input  logic                                   out_ready,
    output logic [W-1:0]                           out_re,
    output logic [W-1:0]                           out_im,
    output logic                                   out_exp_valid,
    output logic signed [$clog2(NUM_PASS*G+1):0]   out_exp
);

    localparam int IW    = W + G;
    localparam int AW    = $clog2(N_PTS);
    localparam int SW    = $clog2(G + 1);
    localparam int EXP_W = $clog2(NUM_PASS * G + 1) + 1;
    localparam int LANES = 2;
    localparam logic [AW-1:0] LAST_IDX = AW'(N_PTS - 1);

    bfp_phase_e              phase_q;
    logic [AW-1:0]           wr_ptr_q;
    logic [AW-1:0]           rd_ptr_q;
    logic [SW-1:0]           run_hr_q;
    logic [SW-1:0]           shift_q;
    logic signed [EXP_W-1:0] exp_q;
    logic                    first_q;
    logic                    last_q;

    logic                    accept;
    logic                    emit;
    logic                    fill_done;
    logic                    pass_first;
    logic                    pass_last;
    logic [SW-1:0]           sample_hr;
    logic [SW-1:0]           block_hr;
    logic [SW-1:0]           block_shift;
    logic signed [EXP_W-1:0] exp_base;
    logic [2*IW-1:0]         rd_word;

    logic [IW-1:0]           lane_in  [LANES];
    logic [SW-1:0]           lane_hr  [LANES];
    logic [IW-1:0]           lane_buf [LANES];
    logic [W-1:0]            lane_out [LANES];

    // Handshake qualifiers.
    assign in_ready  = (phase_q == PH_FILL) && rst_n;
    assign out_valid = (phase_q == PH_DRAIN);
    assign accept    = in_valid && in_ready;
    assign emit      = out_valid && out_ready;
    assign fill_done = accept && (wr_ptr_q == LAST_IDX);

    assign lane_in[0] = in_re;
    assign lane_in[1] = in_im;
    assign lane_buf[0] = rd_word[2*IW-1:IW];
    assign lane_buf[1] = rd_word[IW-1:0];

    // One headroom counter and one output scaler per complex component.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        bfp_sign_bits #(.IW(IW), .CAP(G), .CW(SW)) u_hr (
            .value    (lane_in[ln]),
            .headroom (lane_hr[ln])
        );
        bfp_round_sat #(.IW(IW), .OW(W), .SW(SW)) u_rs (
            .din   (lane_buf[ln]),
            .shamt (shift_q),
            .dout  (lane_out[ln])
        );
    end

    // Worse component of this sample, then worse over the block so far.
    always_comb begin
        sample_hr   = (lane_hr[0] < lane_hr[1]) ? lane_hr[0] : lane_hr[1];
        block_hr    = (sample_hr < run_hr_q) ? sample_hr : run_hr_q;
        block_shift = SW'(G) - block_hr;
    end

    // Pass flags come from the first sample of a pass, latched afterwards.
    always_comb begin
        pass_first = (wr_ptr_q == '0) ? in_first : first_q;
        pass_last  = (wr_ptr_q == '0) ? in_last  : last_q;
        exp_base   = pass_first ? '0 : exp_q;
    end

    bfp_sample_buf #(.DEPTH(N_PTS), .AW(AW), .DW(2*IW)) u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (wr_ptr_q),
        .wr_data ({in_re, in_im}),
        .rd_addr (rd_ptr_q),
        .rd_data (rd_word)
    );

    // Fill/drain sequencing, headroom tracking and exponent update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_FILL;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            run_hr_q <= SW'(G);
            shift_q  <= '0;
            exp_q    <= '0;
            first_q  <= 1'b0;
            last_q   <= 1'b0;
        end else if (phase_q == PH_FILL) begin
            if (accept) begin
                first_q <= pass_first;
                last_q  <= pass_last;
                if (fill_done) begin
                    wr_ptr_q <= '0;
                    rd_ptr_q <= '0;
                    run_hr_q <= SW'(G);
                    shift_q  <= block_shift;
                    exp_q    <= exp_base - $signed(EXP_W'(block_shift));
                    phase_q  <= PH_DRAIN;
                end else begin
                    wr_ptr_q <= wr_ptr_q + AW'(1);
                    run_hr_q <= block_hr;
                end
            end
        end else if (emit) begin
            rd_ptr_q <= rd_ptr_q + AW'(1);
            if (rd_ptr_q == LAST_IDX) begin
                phase_q <= PH_FILL;
            end
        end
    end

    // Output assembly.
    assign out_re        = lane_out[0];
    assign out_im        = lane_out[1];
    assign out_exp_valid = out_valid && last_q;
    assign out_exp       = exp_q;

endmodule

// File: rtl/bfp_pass_scaler_checker.sv
// Module: bfp_pass_scaler_checker
// Port-level properties of the pass scaler, attached by bind.
// Assumes out_ready is a plain level and at most NUM_PASS passes are used.
module bfp_pass_scaler_checker #(
    parameter int N_PTS    = 16,
    parameter int W        = 12,
    parameter int G        = 3,
    parameter int NUM_PASS = 2
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 in_valid,
    input logic                                 in_ready,
    input logic                                 out_valid,
    input logic                                 out_ready,
    input logic [W-1:0]                         out_re,
    input logic [W-1:0]                         out_im,
    input logic                                 out_exp_valid,
    input logic signed [$clog2(NUM_PASS*G+1):0] out_exp
);

    int acc_cnt;

    // Count samples taken since the last drain began.
    always_ff @(posedge clk) begin
        if (!rst_n || out_valid) begin
            acc_cnt <= 0;
        end else if (in_valid && in_ready) begin
            acc_cnt <= acc_cnt + 1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt <= N_PTS);

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

    a_r8_exp_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_exp_valid |-> out_valid);

    a_r8_exp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_exp_valid && $past(out_exp_valid)) |-> $stable(out_exp));

    a_r7_exp_nonpositive: assert property (@(posedge clk) disable iff (!rst_n)
        out_exp <= 0);

endmodule

bind bfp_pass_scaler bfp_pass_scaler_checker #(
    .N_PTS(N_PTS), .W(W), .G(G), .NUM_PASS(NUM_PASS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_re        (out_re),
    .out_im        (out_im),
    .out_exp_valid (out_exp_valid),
    .out_exp       (out_exp)
);

// File: tb/bfp_pass_scaler_test.sv
// Directed bench for bfp_pass_scaler: one task per scenario.
module bfp_pass_scaler_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_PTS = 16;
    localparam int W     = 12;
    localparam int G     = 3;
    localparam int NPASS = 2;
    localparam int IW    = W + G;
    localparam int EW    = $clog2(NPASS * G + 1) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_re = '0;
    logic [IW-1:0] in_im = '0;
    logic          in_first = 1'b0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [W-1:0]  out_re;
    logic [W-1:0]  out_im;
    logic          out_exp_valid;
    logic signed [EW-1:0] out_exp;

    int checks = 0;
    int fails  = 0;
    int re_v [N_PTS];
    int im_v [N_PTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    bfp_pass_scaler #(.N_PTS(N_PTS), .W(W), .G(G), .NUM_PASS(NPASS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_re(in_re), .in_im(in_im), .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re),
        .out_im(out_im), .out_exp_valid(out_exp_valid), .out_exp(out_exp)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit fits(input int x, input int bits);
        return (x >= -(1 <<< (bits - 1))) && (x <= (1 <<< (bits - 1)) - 1);
    endfunction

    // Expected block shift per R3: smallest s with every part fitting W+s bits.
    function automatic int want_shift();
        for (int s = 0; s < G; s++) begin
            bit ok = 1'b1;
            for (int i = 0; i < N_PTS; i++) begin
                if (!fits(re_v[i], W + s) || !fits(im_v[i], W + s)) ok = 1'b0;
            end
            if (ok) return s;
        end
        return G;
    endfunction

    // Expected output per R5/R6: nearest, ties away from zero, then clamp.
    function automatic int want_val(input int x, input int k);
        int r;
        if (k == 0) r = x;
        else if (x >= 0) r = (x + (1 << (k - 1))) / (1 << k);
        else r = -((-x + (1 << (k - 1))) / (1 << k));
        if (r > (1 << (W - 1)) - 1) r = (1 << (W - 1)) - 1;
        if (r < -(1 << (W - 1))) r = -(1 << (W - 1));
        return r;
    endfunction

    task automatic make_block(input int amp, input int seed);
        for (int i = 0; i < N_PTS; i++) begin
            re_v[i] = ((i * 37 + seed) % (2 * amp + 1)) - amp;
            im_v[i] = ((i * 53 + seed * 3) % (2 * amp + 1)) - amp;
        end
    endtask

    // Stream the block in; check the fill boundary (R2).
    task automatic send_pass(input bit first, input bit last);
        for (int i = 0; i < N_PTS; i++) begin
            @(negedge clk);
            if (in_ready !== 1'b1) chk("R2 ready during fill", int'(in_ready), 1);
            in_valid = 1'b1;
            in_re    = IW'(re_v[i]);
            in_im    = IW'(im_v[i]);
            in_first = first;
            in_last  = last;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 in_ready low after fill", int'(in_ready), 0);
        chk("R2 out_valid high after fill", int'(out_valid), 1);
    endtask

    // Drain and compare; optional stall (R9) and junk input (R2).
    task automatic recv_pass(input bit last, input int exp_e, input bit stall, input bit junk);
        int k = want_shift();
        for (int i = 0; i < N_PTS; i++) begin
            if (stall && i == 5) begin
                int hr = $signed(out_re);
                int hi = $signed(out_im);
                out_ready = 1'b0;
                @(negedge clk);
                @(negedge clk);
                chk("R9 valid held", int'(out_valid), 1);
                chk("R9 re held", $signed(out_re), hr);
                chk("R9 im held", $signed(out_im), hi);
            end
            chk("R2 valid in drain", int'(out_valid), 1);
            chk("R4 re", $signed(out_re), want_val(re_v[i], k));
            chk("R4 im", $signed(out_im), want_val(im_v[i], k));
            chk("R8 exp_valid", int'(out_exp_valid), int'(last));
            if (last) chk("R7 exponent", int'(out_exp), exp_e);
            out_ready = 1'b1;
            if (junk) begin
                in_valid = 1'b1;
                in_re = IW'(16383);
                in_im = IW'(-16384);
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk("R10 out_valid low after drain", int'(out_valid), 0);
        chk("R10 in_ready back", int'(in_ready), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in_ready in reset", int'(in_ready), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after reset", int'(in_ready), 1);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 exponent zero", int'(out_exp), 0);
    endtask

    task automatic t_no_growth();
        make_block(2047, 3);
        re_v[2] = -2048;
        im_v[7] = 2047;
        chk("R3 no shift expected", want_shift(), 0);
        send_pass(1'b1, 1'b1);
        recv_pass(1'b1, 0, 1'b0, 1'b1);
    endtask

    task automatic t_full_growth_sat();
        make_block(9000, 11);
        re_v[4] = 16383;
        re_v[9] = -16384;
        chk("R3 three-bit shift expected", want_shift(), 3);
        send_pass(1'b1, 1'b1);
        recv_pass(1'b1, -3, 1'b1, 1'b0);
        chk("R6 saturation value", want_val(16383, 3), 2047);
    endtask

    task automatic t_rounding();
        make_block(300, 5);
        re_v[0] = 5;  im_v[0] = -5;
        re_v[1] = 1;  im_v[1] = -1;
        re_v[2] = 4;  im_v[2] = -3;
        re_v[3] = 3;  im_v[3] = 0;
        im_v[6] = 4095;
        chk("R5 one-bit shift expected", want_shift(), 1);
        chk("R5 5 -> 3", want_val(5, 1), 3);
        chk("R5 -5 -> -3", want_val(-5, 1), -3);
        send_pass(1'b1, 1'b1);
        recv_pass(1'b1, -1, 1'b0, 1'b0);
    endtask

    task automatic t_multipass();
        make_block(6000, 7);
        re_v[1] = 8191;
        chk("R7 pass A shift", want_shift(), 2);
        send_pass(1'b1, 1'b0);
        recv_pass(1'b0, 0, 1'b0, 1'b1);
        make_block(3000, 9);
        im_v[12] = -4096;
        chk("R7 pass B shift", want_shift(), 1);
        send_pass(1'b0, 1'b1);
        recv_pass(1'b1, -3, 1'b1, 1'b0);
        make_block(1000, 2);
        send_pass(1'b1, 1'b1);
        recv_pass(1'b1, 0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_no_growth();
        t_full_growth_sat();
        t_rounding();
        t_multipass();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule